// File: doc/BRIEF.md
# Masked Level Interrupt Combiner

This block gathers a bank of level-sensitive interrupt lines into a source register and combines that register with a programmable enable mask. When any enabled source is active, it drives a single combined interrupt request. It also reports which pending source is the most urgent, as an encoded vector value that a handler can use to pick its service routine.

Software reaches the block through a small register window of 16-bit accesses. A read-only vector sits at byte offset 0x00 and a read/write enable mask sits at byte offset 0x02. The block has no acknowledge and no edge capture. A source stays pending for as long as its line is held high, and the device that raised the line clears it.

Top module: `irqc_top`

## Requirements
- R1: Each cycle the source register loads the interrupt lines: bit i is 1 after a clock edge at which line i was high and 0 after an edge at which it was low.
- R2: The combined request `irq_out` is a register. After every clock edge it equals the OR of (source AND mask) as they stand after that same edge.
- R3: Reading offset 0x00 returns (i+1)<<2, where i is the lowest-numbered bit that is set in both source and mask. Bit 0 has the highest priority and bit 15 the lowest, so source 15 reads 64.
- R4: Reading offset 0x00 returns 0 when no enabled source is active, including when active sources are all masked off.
- R5: A write at offset 0x02 loads all 16 bits of the enable mask, and a read at offset 0x02 returns the mask.
- R6: A mask write takes effect on `irq_out` at the same clock edge that stores the new mask.
- R7: While reset is held and right after it, the mask reads 0x0010, the vector reads 0 and `irq_out` is 0, whatever the lines do.
- R8: Reads of any offset other than 0x00 and 0x02 return 0. Writes to any offset other than 0x02, including the vector at 0x00, leave the mask unchanged.
- R9: Reading the vector any number of times changes neither the source nor the mask state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 16 | Level interrupt lines, bit i is source i |
| reg_wr_en | input | 1 | Write strobe for the register window |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational from state |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle, assertions check four things. The source register follows the lines with one edge of delay. The mask holds unless its own offset is written, and it loads the written data when that offset is written. `irq_out` agrees with the stored source and mask. Any nonzero vector is word-aligned and points at a bit that really is pending, and a zero pending set always yields a zero vector. Other behaviours can only be shown by the bench scenarios: that the lowest index wins among several pending bits, the reset value of the mask, reads of unmapped offsets, and that repeated vector reads leave state untouched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register selected by the current access offset.
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_VEC  = 2'd1,
        REG_MASK = 2'd2
    } irqc_reg_e;

endpackage

// File: rtl/irqc_src_sync.sv
module irqc_src_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    output logic [N-1:0] src_d,
    output logic [N-1:0] src_q
);

    typedef struct packed {
        logic [N-1:0] src;
    } src_state_t;

    src_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.src = lvl_in;   // level sources: set while high, clear while low
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_d = st_d.src;
    assign src_q = st_q.src;

    // R1: register follows the lines one edge later
    assert_src_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (src_q == $past(lvl_in)));

endmodule

// File: rtl/irqc_prio_vec.sv
module irqc_prio_vec #(
    parameter int N  = 16,
    parameter int VW = $clog2(N + 1) + 2
) (
    input  logic [N-1:0]  pend,
    output logic [VW-1:0] vec
);

    // Scan from the top so the lowest pending index is the last to win.
    always_comb begin
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) vec = VW'((i + 1) << 2);
        end
    end

endmodule

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs
    import irqc_pkg::*;
#(
    parameter int             N        = 16,
    parameter int             AW       = 12,
    parameter int             DW       = 16,
    parameter logic [AW-1:0]  VEC_OFS  = 'h0,
    parameter logic [AW-1:0]  MASK_OFS = 'h2,
    parameter logic [N-1:0]   MASK_RST = N'(16'h0010)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output irqc_reg_e     sel,
    output logic [N-1:0]  mask_d,
    output logic [N-1:0]  mask_q
);

    typedef struct packed {
        logic [N-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        if (addr == VEC_OFS)       sel = REG_VEC;
        else if (addr == MASK_OFS) sel = REG_MASK;
        else                       sel = REG_NONE;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && (sel == REG_MASK)) st_d.mask = wdata[N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mask <= MASK_RST;
        else        st_q      <= st_d;
    end

    assign mask_d = st_d.mask;
    assign mask_q = st_q.mask;

    // R5: a write to the mask offset loads the data
    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MASK_OFS) |=> (mask_q == $past(wdata[N-1:0])));

    // R8: any other cycle leaves the mask alone
    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == MASK_OFS) |=> $stable(mask_q));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_lvl,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_out
);

    localparam int VW = $clog2(N + 1) + 2;

    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t     st_d, st_q;
    logic [N-1:0]   src_d, src_q;
    logic [N-1:0]   mask_d, mask_q;
    logic [N-1:0]   pend_q;
    logic [VW-1:0]  vec;
    irqc_reg_e      sel;

    irqc_src_sync #(.N(N)) i_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (irq_lvl),
        .src_d  (src_d),
        .src_q  (src_q)
    );

    irqc_mask_regs #(.N(N), .AW(AW), .DW(DW)) i_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .sel    (sel),
        .mask_d (mask_d),
        .mask_q (mask_q)
    );

    assign pend_q = src_q & mask_q;

    irqc_prio_vec #(.N(N), .VW(VW)) i_prio (
        .pend (pend_q),
        .vec  (vec)
    );

    // Request is formed from next values so it lands with the state it reflects.
    always_comb begin
        st_d     = st_q;
        st_d.irq = |(src_d & mask_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out = st_q.irq;

    always_comb begin
        case (sel)
            REG_VEC:  reg_rdata = DW'(vec);
            REG_MASK: reg_rdata = DW'(mask_q);
            default:  reg_rdata = '0;
        endcase
    end

    // R2: registered request agrees with stored source and mask
    assert_irq_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (pend_q != '0));

    // R4: empty pending set yields a zero vector
    assert_vec_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (vec == '0));

    // R3: a nonzero vector is word aligned and names a pending bit
    assert_vec_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != '0) |-> (vec[1:0] == 2'b00 && pend_q[int'(vec >> 2) - 1]));

endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lvl = 16'hFFFF;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_src = 16'h0;
    logic [15:0] m_mask = 16'h0010;

    typedef struct {
        bit          is_irq;
        logic [15:0] exp;
        int          req;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    irqc_top i_irqc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lvl   (irq_lvl),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    function automatic logic [15:0] model_vec(logic [15:0] p);
        logic [15:0] v = 16'h0;
        for (int i = 15; i >= 0; i--) if (p[i]) v = 16'((i + 1) << 2);
        return v;
    endfunction

    task automatic push(bit is_irq, logic [15:0] exp, int req);
        item_t it;
        it.is_irq = is_irq;
        it.exp    = exp;
        it.req    = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compares after each edge, away from it.
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {15'b0, irq_out} : reg_rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL R%0d: %s actual=%h expected=%h", it.req,
                         it.is_irq ? "irq_out" : "rdata", act, it.exp);
            end
        end
    end

    task automatic set_lvl(logic [15:0] v, int req);
        @(negedge clk);
        irq_lvl  = v;
        m_src    = v;
        reg_addr = 12'h000;
        push(1'b0, model_vec(m_src & m_mask), req);
        push(1'b1, {15'b0, |(m_src & m_mask)}, req);
    endtask

    task automatic wr(logic [11:0] a, logic [15:0] d, int req);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        if (a == 12'h002) m_mask = d;
        push(1'b1, {15'b0, |(m_src & m_mask)}, req);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [15:0] exp, int req);
        @(negedge clk);
        reg_addr = a;
        push(1'b0, exp, req);
    endtask

    initial begin
        // R7: reset state while lines are all high
        rd(12'h002, 16'h0010, 7);
        rd(12'h000, 16'h0000, 7);
        @(negedge clk); push(1'b1, 16'h0, 7);
        @(negedge clk); rst_n = 1'b1;
        rd(12'h002, 16'h0010, 7);

        // R1 R2 R3: all lines high, default mask lets source 4 through -> 20
        set_lvl(16'hFFFF, 3);
        // R4: active source masked off
        set_lvl(16'h0001, 4);
        // R6: opening the mask raises the request on the write edge
        wr(12'h002, 16'hFFFF, 6);
        rd(12'h000, 16'h0004, 3);
        // R3: lowest index wins
        set_lvl(16'h8100, 3);
        set_lvl(16'h8000, 3);
        // R5: mask readback
        rd(12'h002, 16'hFFFF, 5);
        // R6: closing the mask drops the request
        wr(12'h002, 16'h00F0, 6);
        rd(12'h002, 16'h00F0, 5);
        // R8: writes to vector and unmapped offsets ignored, unmapped reads zero
        wr(12'h000, 16'h1234, 8);
        rd(12'h002, 16'h00F0, 8);
        wr(12'h004, 16'hFFFF, 8);
        rd(12'h002, 16'h00F0, 8);
        rd(12'h004, 16'h0000, 8);
        rd(12'h003, 16'h0000, 8);
        rd(12'hFFE, 16'h0000, 8);
        // R9: repeated vector reads have no side effect
        set_lvl(16'h0060, 3);
        rd(12'h000, 16'd24, 9);
        rd(12'h000, 16'd24, 9);
        rd(12'h000, 16'd24, 9);
        rd(12'h002, 16'h00F0, 9);
        // R1: lines low clear the sources
        set_lvl(16'h0000, 1);
        @(negedge clk); push(1'b1, 16'h0, 2);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule